// File: doc/BRIEF.md
# Parallel NOR Flash Read State and Page Buffer

This block is the device-side read path of a parallel NOR flash, written as a clocked, synthesizable model around a small computed array. Commands written over the bus choose one of four read states: array contents, identifier codes, status or query data. Reads are asynchronous page reads. The first access to a page waits a fixed number of system clocks while a whole 4-word page is sensed into a buffer. After that, the lowest address bits choose the buffered word on the 16-bit data bus in the same cycle, with no further delay.

The address is either transparent while address-valid is held low, or captured when address-valid rises. Chip enable must be low and write enable high for data to be driven. A write cycle, or the release of chip enable, discards the buffered page. WAIT is never asserted, because only asynchronous reads exist here.

Top module: `nor_page_reader`

## Requirements
- R1: After reset the read state is array, `dq_oe` is 0, `dout` is 0 and `wait_o` is 0.
- R2: In the array state the word at address a is {a[7:0] xor 8'h3C, ~a[7:0]}.
- R3: After a read starts on a page that is not buffered, `dq_oe` stays 0 for LATENCY rising edges (default 3), counting the first edge at which the new address is present. It is 1 after the next edge.
- R4: While address bits above [1:0] stay the same, a change of addr[1:0] alone gives the new word at once, and `dq_oe` stays 1 across later clock edges.
- R5: A change of any address bit above bit 1 drops `dq_oe` and pays the full latency again.
- R6: A write of 16'h0090 selects identifier reads, where offset 0 (addr[1:0]=00) gives 16'h00C2, offset 1 gives 16'h227E and other offsets give 0. A write of 16'h0070 selects status reads, which give 16'h0080 at any address. A write of 16'h0098 selects query reads, which give 16'h0051 at any address.
- R7: A write of any other value, including a known code with a nonzero upper byte, leaves the read state unchanged.
- R8: Array data comes back after a non-array state only once 16'h00FF has been written.
- R9: Data is driven only while `ce_n` is 0 and `we_n` is 1. Otherwise `dq_oe` is 0 and `dout` is 0.
- R10: With `adv_n` held low the address is transparent. When `adv_n` rises, the address present at the last edge with `adv_n` low is held, and later changes on `addr` are ignored.
- R11: `wait_o` is always 0.
- R12: Raising `ce_n` for one clock edge discards the buffered page, so a later read of the same page pays the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that counts the access latency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW (10) | Word address |
| din | input | 16 | Command data written on a write cycle |
| dout | output | 16 | Read data, 0 when not driven |
| dq_oe | output | 1 | High while `dout` carries valid read data |
| wait_o | output | 1 | Wait indication, held low |

## Verification
The bench checks that the output enable stays low for exactly the latency and no longer. A counter off by one would show data one edge early or late. It moves only the low address bits within a page, to catch a design that reloads on every address change. It then crosses a page boundary, to catch one that serves stale buffered words. It writes an unknown code while in identifier state, reads again after a one-edge chip-enable release, and changes the address after address-valid rises. A design that fell back to array reads, kept a stale page, or followed the live address would then return the wrong word.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;

   typedef enum logic [1:0] {
      RS_ARRAY  = 2'd0,
      RS_IDENT  = 2'd1,
      RS_STATUS = 2'd2,
      RS_QUERY  = 2'd3
   } rd_state_e;

   localparam logic [15:0] CMD_GO_ARRAY  = 16'h00FF;
   localparam logic [15:0] CMD_GO_IDENT  = 16'h0090;
   localparam logic [15:0] CMD_GO_STATUS = 16'h0070;
   localparam logic [15:0] CMD_GO_QUERY  = 16'h0098;

   // contents of the small read-only array, derived from the low address byte
   function automatic logic [15:0] array_word(input logic [7:0] lo);
      return {lo ^ 8'h3C, ~lo};
   endfunction

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
   import nor_rd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_stb,
   input  logic [15:0] cmd,
   output rd_state_e state
);

   rd_state_e state_q;
   logic      known;

   always_comb begin
      known = (cmd == CMD_GO_ARRAY) || (cmd == CMD_GO_IDENT) ||
              (cmd == CMD_GO_STATUS) || (cmd == CMD_GO_QUERY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_ARRAY;
      end else if (wr_stb) begin
         case (cmd)
            CMD_GO_ARRAY:  state_q <= RS_ARRAY;
            CMD_GO_IDENT:  state_q <= RS_IDENT;
            CMD_GO_STATUS: state_q <= RS_STATUS;
            CMD_GO_QUERY:  state_q <= RS_QUERY;
            default:       state_q <= state_q;
         endcase
      end
   end

   assign state = state_q;

   // R7: an unrecognised write keeps the read state
   assert_unknown_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !known) |=> $stable(state_q));

   // R8: the read-array code always returns to array reads
   assert_array_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cmd == CMD_GO_ARRAY) |=> (state_q == RS_ARRAY));

endmodule

// File: rtl/nor_addr_capture.sv
module nor_addr_capture #(
   parameter int unsigned AW        = 10,
   parameter bit          ADV_LATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_n,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] eff_addr
);

   if (AW < 8) begin : g_bad_aw
      $error("nor_addr_capture: AW must be at least 8");
   end

   if (ADV_LATCH) begin : g_latch
      logic [AW-1:0] lat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lat_q <= '0;
         else if (!adv_n) lat_q <= addr;
      end

      assign eff_addr = adv_n ? lat_q : addr;

      // R10: once address-valid is high the captured address holds
      assert_latch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         adv_n |=> $stable(lat_q));
   end else begin : g_transparent
      logic unused_adv;
      logic unused_clk;
      logic unused_rst;
      assign unused_adv = adv_n;
      assign unused_clk = clk;
      assign unused_rst = rst_n;
      assign eff_addr   = addr;
   end

endmodule

// File: rtl/nor_page_buf.sv
module nor_page_buf
   import nor_rd_pkg::*;
#(
   parameter int unsigned AW        = 10,
   parameter int unsigned PAGE_BITS = 2,
   parameter int unsigned LATENCY   = 3,
   parameter logic [15:0] ID_MFR    = 16'h00C2,
   parameter logic [15:0] ID_DEV    = 16'h227E,
   parameter logic [15:0] ST_READY  = 16'h0080,
   parameter logic [15:0] QRY_FILL  = 16'h0051
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_act,
   input  logic [AW-1:0] eff_addr,
   input  rd_state_e     state,
   output logic          hit,
   output logic [15:0]   out_word
);

   localparam int unsigned PAGE_WORDS = 1 << PAGE_BITS;
   localparam int unsigned TW         = AW - PAGE_BITS;
   localparam int unsigned CW         = $clog2(LATENCY + 1);

   if (LATENCY < 1) begin : g_bad_lat
      $error("nor_page_buf: LATENCY must be at least 1");
   end
   if (PAGE_BITS < 2 || PAGE_BITS >= AW) begin : g_bad_page
      $error("nor_page_buf: PAGE_BITS must be at least 2 and below AW");
   end

   function automatic logic [15:0] sense(input rd_state_e st, input logic [7:0] lo);
      case (st)
         RS_ARRAY:  return array_word(lo);
         RS_IDENT:  return (lo[1:0] == 2'd0) ? ID_MFR :
                           (lo[1:0] == 2'd1) ? ID_DEV : 16'h0000;
         RS_STATUS: return ST_READY;
         default:   return QRY_FILL;
      endcase
   endfunction

   logic [TW-1:0] tag_q;
   logic          vld_q;
   logic          loading_q;
   logic [CW-1:0] cnt_q;
   logic [15:0]   page_q [PAGE_WORDS];
   logic [TW-1:0] eff_tag;
   logic          tag_eq;
   logic          load_done;

   assign eff_tag   = eff_addr[AW-1:PAGE_BITS];
   assign tag_eq    = (tag_q == eff_tag);
   assign hit       = vld_q && tag_eq;
   assign load_done = rd_act && loading_q && tag_eq && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q     <= '0;
         vld_q     <= 1'b0;
         loading_q <= 1'b0;
         cnt_q     <= '0;
      end else if (!rd_act) begin
         vld_q     <= 1'b0;
         loading_q <= 1'b0;
      end else if (hit) begin
         vld_q     <= 1'b1;
      end else if (!loading_q || !tag_eq) begin
         loading_q <= 1'b1;
         cnt_q     <= CW'(LATENCY - 1);
         tag_q     <= eff_tag;
         vld_q     <= 1'b0;
      end else if (cnt_q == '0) begin
         vld_q     <= 1'b1;
         loading_q <= 1'b0;
      end else begin
         cnt_q     <= cnt_q - CW'(1);
      end
   end

   for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         page_q[w] <= '0;
         else if (load_done) page_q[w] <= sense(state, 8'({tag_q, PAGE_BITS'(w)}));
      end
   end

   assign out_word = page_q[eff_addr[PAGE_BITS-1:0]];

   // R12 / R9: leaving the read condition discards the page
   assert_drop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_act |=> !vld_q);

   // R3: the page becomes valid only after the latency count ran out
   assert_fill_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> ($past(loading_q) && $past(cnt_q) == '0));

   // R4: a hit in the buffered page keeps it valid
   assert_hit_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && hit) |=> vld_q);

endmodule

// File: rtl/nor_page_reader.sv
module nor_page_reader
   import nor_rd_pkg::*;
#(
   parameter int unsigned AW        = 10,
   parameter int unsigned PAGE_BITS = 2,
   parameter int unsigned LATENCY   = 3,
   parameter bit          ADV_LATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          adv_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [15:0]   din,
   output logic [15:0]   dout,
   output logic          dq_oe,
   output logic          wait_o
);

   logic          rd_act;
   logic          wr_stb;
   logic [AW-1:0] eff_addr;
   logic          hit;
   logic [15:0]   out_word;
   rd_state_e     state;

   assign rd_act = !ce_n && we_n;
   assign wr_stb = !ce_n && !we_n;

   nor_cmd_decode u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .cmd    (din),
      .state  (state)
   );

   nor_addr_capture #(
      .AW        (AW),
      .ADV_LATCH (ADV_LATCH)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_n    (adv_n),
      .addr     (addr),
      .eff_addr (eff_addr)
   );

   nor_page_buf #(
      .AW        (AW),
      .PAGE_BITS (PAGE_BITS),
      .LATENCY   (LATENCY)
   ) u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (rd_act),
      .eff_addr (eff_addr),
      .state    (state),
      .hit      (hit),
      .out_word (out_word)
   );

   assign dq_oe  = rd_act && hit;
   assign dout   = dq_oe ? out_word : 16'h0000;
   assign wait_o = 1'b0;

endmodule

// File: tb/nor_page_reader_tb.sv
module nor_page_reader_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 10;
   localparam int LAT        = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic          dq_oe;
   logic          wait_o;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nor_page_reader #(.AW(AW), .LATENCY(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe), .wait_o(wait_o)
   );

   // {command written first (0 = none), read address, expected word}
   localparam logic [41:0] VEC [10] = '{
      {16'h0000, 10'h004, 16'h38FB},   // R1 R2 array after reset
      {16'h0000, 10'h125, 16'h19DA},   // R2
      {16'h0090, 10'h000, 16'h00C2},   // R6 identifier offset 0
      {16'h0000, 10'h001, 16'h227E},   // R6 identifier offset 1
      {16'h0000, 10'h002, 16'h0000},   // R6 identifier other offset
      {16'h0042, 10'h001, 16'h227E},   // R7 unknown code
      {16'h0070, 10'h3FF, 16'h0080},   // R6 status
      {16'h0098, 10'h010, 16'h0051},   // R6 query
      {16'h00FF, 10'h3FF, 16'hC300},   // R8 back to array
      {16'h0000, 10'h0AA, 16'h9655}    // R2
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_cmd(input logic [15:0] c);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; din = c;
      @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
   endtask

   task automatic end_cycle();
      @(negedge clk); ce_n = 1'b1; adv_n = 1'b1;
   endtask

   // full read of a page not yet buffered, checking the latency edge (R3)
   task automatic page_read(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk); ce_n = 1'b0; we_n = 1'b1; adv_n = 1'b0; addr = a;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk({tag, " R3 oe low during latency"}, 32'(dq_oe), 32'd0);
      @(posedge clk); @(negedge clk);
      chk({tag, " R3 oe high after latency"}, 32'(dq_oe), 32'd1);
      chk({tag, " data"}, 32'(dout), 32'(exp));
      chk({tag, " R11 wait low"}, 32'(wait_o), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 dout in reset", 32'(dout), 32'd0);
      chk("R1 oe in reset", 32'(dq_oe), 32'd0);
      chk("R11 wait in reset", 32'(wait_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", 32'(dq_oe), 32'd0);

      // vector walk: R1 R2 R6 R7 R8
      for (int i = 0; i < 10; i++) begin
         if (VEC[i][41:26] != 16'h0000) write_cmd(VEC[i][41:26]);
         page_read(VEC[i][25:16], VEC[i][15:0], $sformatf("vec%0d R2/R6/R7/R8", i));
         end_cycle();
      end

      // R4: word change inside the page
      page_read(10'h004, 16'h38FB, "R4 setup");
      addr = 10'h006;
      #1 chk("R4 in-page word at once", 32'(dout), 32'h3AF9);
      @(posedge clk); @(negedge clk);
      chk("R4 oe kept after edge", 32'(dq_oe), 32'd1);
      chk("R4 in-page word after edge", 32'(dout), 32'h3AF9);

      // R5: page change reloads
      addr = 10'h008;
      @(posedge clk); @(negedge clk);
      chk("R5 oe drops on page change", 32'(dq_oe), 32'd0);
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk("R5 oe low until full latency", 32'(dq_oe), 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R5 oe after reload", 32'(dq_oe), 32'd1);
      chk("R5 new page word", 32'(dout), 32'h34F7);
      end_cycle();

      // R12: chip enable release discards the page
      page_read(10'h004, 16'h38FB, "R12 setup");
      end_cycle();
      @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = 10'h004;
      @(posedge clk); @(negedge clk);
      chk("R12 same page reloads", 32'(dq_oe), 32'd0);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk("R12 data after reload", 32'(dout), 32'h38FB);
      end_cycle();

      // R10: capture on address-valid rise
      @(negedge clk); ce_n = 1'b0; adv_n = 1'b0; addr = 10'h020;
      @(negedge clk); adv_n = 1'b1;
      @(negedge clk); addr = 10'h300;
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk("R10 latched address used", 32'(dout), 32'h1CDF);
      chk("R10 oe with latched address", 32'(dq_oe), 32'd1);
      end_cycle();

      // R9: no drive during write or with chip enable high
      @(negedge clk); ce_n = 1'b0; we_n = 1'b0; adv_n = 1'b0; addr = 10'h004; din = 16'h0000;
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk);
      chk("R9 oe low while write enable low", 32'(dq_oe), 32'd0);
      chk("R9 dout zero while write enable low", 32'(dout), 32'd0);
      we_n = 1'b1; ce_n = 1'b1;
      repeat (LAT + 2) @(posedge clk);
      @(negedge clk);
      chk("R9 oe low with chip enable high", 32'(dq_oe), 32'd0);
      // zero-upper-byte rule of R7: 16'h0190 is not the identifier code
      write_cmd(16'h0190);
      page_read(10'h004, 16'h38FB, "R7 upper byte");
      end_cycle();

      // R1: reset from identifier state returns to array reads
      write_cmd(16'h0090);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      page_read(10'h004, 16'h38FB, "R1 array after reset");
      end_cycle();

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule